// File: doc/BRIEF.md
# Interleaved Four-Bank Cache Line Fill Controller

This block serves cache-line refills from main memory that is split into four word-wide banks. A refill asks for one 16-byte line, which is four 32-bit words. Word i of every line lives in bank i. The controller sends the line address to all banks at once and holds the bank selects for one access time, so the four banks work in parallel. It then passes the four captured words to the cache over a 4-byte path, one word per transfer slot. Each word comes with a valid pulse and its word index.

A second mode copies a memory that is only one word wide, for comparison. In this mode the banks are selected one at a time, and each word waits out a full access of its own before its transfer. Every phase length is a parameter counted in clock cycles. The defaults are 2 cycles for the address phase, 50 for an access and 2 per word transfer. With these defaults a fill takes 60 cycles in interleaved mode and 210 cycles in one-word mode.

Top module: `ilv_line_fill`

## Requirements
- R1: After reset, `ready` is high, `word_valid` and `fill_done` are low, and `bank_sel` is zero.
- R2: A request is accepted only when `ready` is high. `ready` drops in the cycle after acceptance and stays low through the cycle in which `fill_done` is high. A request raised while `ready` is low has no effect on the fill in progress or on the next one.
- R3: In interleaved mode (`narrow_mode`=0), `bank_sel` is 4'b1111 for exactly T_ACC cycles, starting T_ADDR cycles after acceptance. It is zero at every other time.
- R4: In interleaved mode, word i is presented in cycle T_ADDR+T_ACC+(i+1)*T_XFER, counting the cycle after the accepting edge as cycle 1. With the defaults the last word arrives in cycle 60.
- R5: In one-word mode (`narrow_mode`=1), word i is presented in cycle T_ADDR+(i+1)*(T_ACC+T_XFER). With the defaults the last word arrives in cycle 210.
- R6: In one-word mode, bit i of `bank_sel` is the only bit set, for T_ACC cycles. This window starts at cycle T_ADDR+i*(T_ACC+T_XFER)+1, and the banks are visited in the order 0 to 3.
- R7: Each fill gives exactly four single-cycle `word_valid` pulses, with `word_idx` running 0, 1, 2, 3. `word_data` equals what bank `word_idx` drove during its select window.
- R8: `fill_done` is high for one cycle, right after the last word. `ready` is high in the following cycle.
- R9: The line address and the mode are captured at acceptance. `bank_addr` holds the captured address, and changes on `line_addr` or `narrow_mode` during a fill have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fill_req | input | 1 | Fill request, accepted when `ready` is high |
| line_addr | input | LA_W | Line address of the requested fill |
| narrow_mode | input | 1 | 1 selects one-word-wide emulation |
| ready | output | 1 | High when idle and able to accept a request |
| word_valid | output | 1 | One-cycle strobe for each delivered word |
| word_idx | output | IW | Index of the delivered word within the line |
| word_data | output | DW | Delivered word |
| fill_done | output | 1 | One-cycle pulse after the fourth word |
| bank_addr | output | LA_W | Captured line address driven to every bank |
| bank_sel | output | WORDS | Per-bank access select |
| bank_rdata | input | WORDS*DW | Bank read data, bank i in slice i |

## Verification
A wrong state or counter value shows up at the ports as a word strobe or bank-select window that starts in the wrong cycle. It is visible within one cycle of the slip, because every expected edge is checked cycle by cycle. The bench banks return data only while selected, so a word captured in the wrong cycle or from the wrong bank comes out as zero or as another bank's pattern. This is caught on that word's strobe. Requests, addresses and mode changes raised during a busy fill appear as a changed `bank_addr`, a shifted strobe or a wrong data pattern. These show up in the same fill or in the one after it.

// File: rtl/ilv_line_fill.sv
module ilv_line_fill #(
  parameter int DW     = 32,
  parameter int WORDS  = 4,
  parameter int LA_W   = 28,
  parameter int T_ADDR = 2,
  parameter int T_ACC  = 50,
  parameter int T_XFER = 2,
  localparam int IW    = $clog2(WORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fill_req,
  input  logic [LA_W-1:0]       line_addr,
  input  logic                  narrow_mode,
  output logic                  ready,
  output logic                  word_valid,
  output logic [IW-1:0]         word_idx,
  output logic [DW-1:0]         word_data,
  output logic                  fill_done,
  output logic [LA_W-1:0]       bank_addr,
  output logic [WORDS-1:0]      bank_sel,
  input  logic [WORDS*DW-1:0]   bank_rdata
);

  localparam int TMAX = (T_ACC > T_ADDR) ? ((T_ACC > T_XFER) ? T_ACC : T_XFER)
                                         : ((T_ADDR > T_XFER) ? T_ADDR : T_XFER);
  localparam int CW = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACCESS, S_XFER, S_DONE} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   widx;
  logic            mode_q;
  logic [LA_W-1:0] addr_q;
  logic [DW-1:0]   wbuf [WORDS];

  wire addr_end = (cnt == CW'(T_ADDR - 1));
  wire acc_end  = (cnt == CW'(T_ACC - 1));
  wire xfer_end = (cnt == CW'(T_XFER - 1));
  wire last_w   = (widx == IW'(WORDS - 1));

  assign ready      = (st == S_IDLE);
  assign fill_done  = (st == S_DONE);
  assign word_valid = (st == S_XFER) && xfer_end;
  assign word_idx   = widx;
  assign word_data  = wbuf[widx];
  assign bank_addr  = addr_q;
  assign bank_sel   = (st != S_ACCESS) ? '0 :
                      mode_q ? (WORDS'(1) << widx) : {WORDS{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      widx   <= '0;
      mode_q <= 1'b0;
      addr_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (fill_req) begin
          addr_q <= line_addr;
          mode_q <= narrow_mode;
          widx   <= '0;
          cnt    <= '0;
          st     <= S_ADDR;
        end
        S_ADDR: begin
          cnt <= addr_end ? '0 : cnt + 1'b1;
          if (addr_end) st <= S_ACCESS;
        end
        S_ACCESS: begin
          cnt <= acc_end ? '0 : cnt + 1'b1;
          if (acc_end) st <= S_XFER;
        end
        S_XFER: begin
          cnt <= xfer_end ? '0 : cnt + 1'b1;
          if (xfer_end) begin
            if (last_w) st <= S_DONE;
            else begin
              widx <= widx + 1'b1;
              st   <= mode_q ? S_ACCESS : S_XFER;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_ACCESS && acc_end)
      for (int i = 0; i < WORDS; i++)
        if (bank_sel[i]) wbuf[i] <= bank_rdata[i*DW +: DW];
  end

endmodule

// File: rtl/ilv_line_fill_chk.sv
module ilv_line_fill_chk #(
  parameter int WORDS = 4,
  localparam int IW   = $clog2(WORDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fill_req,
  input logic             ready,
  input logic             word_valid,
  input logic [IW-1:0]    word_idx,
  input logic             fill_done,
  input logic [WORDS-1:0] bank_sel
);

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ready && fill_req |=> !ready); // R2

  AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !ready); // R2

  AST_NO_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> bank_sel == '0); // R3

  AST_SEL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel != '0 |-> (bank_sel == {WORDS{1'b1}} || $onehot0(bank_sel))); // R6

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_idx != IW'(WORDS - 1) |=> word_idx == $past(word_idx) + 1'b1); // R7

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_idx == IW'(WORDS - 1) |=> fill_done); // R8

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> ready); // R8

endmodule

bind ilv_line_fill ilv_line_fill_chk #(.WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .ready(ready),
  .word_valid(word_valid), .word_idx(word_idx), .fill_done(fill_done),
  .bank_sel(bank_sel)
);

// File: tb/ilv_line_fill_tb.sv
module ilv_line_fill_tb;
  localparam int DW = 32, WORDS = 4, LA_W = 28;
  localparam int T_ADDR = 2, T_ACC = 50, T_XFER = 2;

  logic clk = 0, rst_n = 0;
  logic fill_req = 0, narrow_mode = 0;
  logic [LA_W-1:0] line_addr = '0;
  logic ready, word_valid, fill_done;
  logic [1:0] word_idx;
  logic [DW-1:0] word_data;
  logic [LA_W-1:0] bank_addr;
  logic [WORDS-1:0] bank_sel;
  logic [WORDS*DW-1:0] bank_rdata;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ilv_line_fill #(.DW(DW), .WORDS(WORDS), .LA_W(LA_W), .T_ADDR(T_ADDR),
                  .T_ACC(T_ACC), .T_XFER(T_XFER)) u_dut (
    .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .line_addr(line_addr),
    .narrow_mode(narrow_mode), .ready(ready), .word_valid(word_valid),
    .word_idx(word_idx), .word_data(word_data), .fill_done(fill_done),
    .bank_addr(bank_addr), .bank_sel(bank_sel), .bank_rdata(bank_rdata));

  function automatic logic [DW-1:0] pat(int b, logic [LA_W-1:0] a);
    return (DW'(a) * 32'h9E3779B1) ^ (32'h01010101 * (b + 1)) ^ 32'hA5A50000;
  endfunction

  always_comb
    for (int i = 0; i < WORDS; i++)
      bank_rdata[i*DW +: DW] = bank_sel[i] ? pat(i, bank_addr) : '0;

  function automatic int exp_word(int c, bit m);
    for (int i = 0; i < WORDS; i++) begin
      int t = m ? T_ADDR + (i + 1) * (T_ACC + T_XFER) : T_ADDR + T_ACC + (i + 1) * T_XFER;
      if (c == t) return i;
    end
    return -1;
  endfunction

  function automatic logic [WORDS-1:0] exp_sel(int c, bit m);
    for (int k = 0; k < WORDS; k++) begin
      int s = m ? T_ADDR + k * (T_ACC + T_XFER) + 1 : T_ADDR + 1;
      if (c >= s && c < s + T_ACC) return m ? WORDS'(1) << k : {WORDS{1'b1}};
    end
    return '0;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_fill(logic [LA_W-1:0] a, bit m, bit noise);
    int last = m ? T_ADDR + WORDS * (T_ACC + T_XFER) : T_ADDR + T_ACC + WORDS * T_XFER;
    int sel_bad = 0, rdy_bad = 0, done_bad = 0, addr_bad = 0, vcnt = 0;
    @(negedge clk);
    check(ready, "R2", "ready before request", ready, 1);
    line_addr = a; narrow_mode = m; fill_req = 1;
    @(negedge clk);
    for (int c = 1; c <= last + 2; c++) begin
      int w = exp_word(c, m);
      if (bank_sel !== exp_sel(c, m)) sel_bad++;
      if (ready !== (c == last + 2)) rdy_bad++;
      if (fill_done !== (c == last + 1)) done_bad++;
      if (bank_addr !== a) addr_bad++;
      if (word_valid !== (w >= 0)) begin
        check(0, m ? "R5" : "R4", $sformatf("word_valid in cycle %0d", c), word_valid, w >= 0);
      end
      if (word_valid && w >= 0) begin
        vcnt++;
        check(word_idx == w, "R7", "word_idx", word_idx, w);
        check(word_data == pat(w, a), "R7", "word_data", word_data, pat(w, a));
      end
      if (c <= last && noise) begin
        fill_req = 1'($urandom); line_addr = LA_W'($urandom); narrow_mode = 1'($urandom);
      end else fill_req = 0;
      if (c < last + 2) @(negedge clk);
    end
    check(vcnt == WORDS, m ? "R5" : "R4", "word pulses on time", vcnt, WORDS);
    check(sel_bad == 0, m ? "R6" : "R3", "bank_sel mismatching cycles", sel_bad, 0);
    check(rdy_bad == 0, "R2", "ready mismatching cycles", rdy_bad, 0);
    check(done_bad == 0, "R8", "fill_done mismatching cycles", done_bad, 0);
    check(addr_bad == 0, "R9", "bank_addr mismatching cycles", addr_bad, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #3;
    check(ready == 1 && word_valid == 0 && fill_done == 0 && bank_sel == 0,
          "R1", "reset outputs", {ready, word_valid, fill_done, bank_sel}, 7'b1000000);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(ready == 1 && bank_sel == 0, "R1", "after reset release", ready, 1);
    do_fill(28'h0000000, 0, 0);
    do_fill(28'hFFFFFFF, 1, 0);
    do_fill(28'h1234567, 0, 1);
    do_fill(28'h0ABCDEF, 1, 1);
    for (int n = 0; n < 16; n++)
      do_fill(LA_W'($urandom), 1'($urandom), 1'($urandom));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule